// File: doc/BRIEF.md
# Exclusive Split-L1 / L2 Request Steering

This block stands in front of a cache hierarchy made of an instruction L1, a data L1 and a unified L2. The three arrays are kept mutually exclusive, so any line lives in at most one of them. For the request at the head of the processor queue, the block reads the tag-presence and free-way indications of the three arrays and picks exactly one action. It either passes the request on as an access (hit or miss in the proper L1), pulls the line up from L2, pushes a line down from an L1 into L2, or evicts a line from L2 to make room.

A line that sits in the wrong L1, or a proper L1 that is full, is migrated through the L2. When the L2 set has no room, an L2 eviction comes first. A single request can therefore take several steering steps. Only the final access consumes it. Each step after the first re-evaluates the same request against the array state that the previous action left behind.

The block sends one lookup address (`probeAddr`) to the L2 room/victim port. It reports each decision as a one-cycle, one-hot event with a target address, and then waits one idle cycle so that the arrays can apply the action before the next decision.

Top module: `excl_cache_steer`

## Requirements
- R1: If the request line is reported present in more than one of the three arrays, the block issues the conflict event (code bit 7) at the request address and pops the request.
- R2: If the line sits only in the other L1 (the data L1 for a fetch, the instruction L1 for a load, store or atomic) and the L2 has room at the request address, the block issues L1-to-L2 (bit 3) at the request address and does not pop.
- R3: If the line sits only in the other L1 and the L2 has no room at the request address, the block issues L2-evict (bit 6) at the L2 victim returned for the request address and does not pop.
- R4: If the line sits only in its proper L1, the block issues the access event at the request address and pops. Request kind 0 (load) maps to bit 0, kind 1 (fetch) to bit 1, and kinds 2 (store) and 3 (atomic) to bit 2.
- R5: If the line is in neither L1, the proper L1 set has a free way and L2 holds the line, the block issues L2-to-data-L1 (bit 4) or L2-to-instruction-L1 (bit 5) at the request address and does not pop.
- R6: If the line is in no array and the proper L1 set has a free way, the block issues the access event of R4 (a miss) at the request address and pops.
- R7: If the line is in neither L1 and the proper L1 set is full, the block acts on that L1's victim address without popping. It issues L1-to-L2 (bit 3) at the victim when the L2 has room for the victim, and otherwise L2-evict (bit 6) at the L2 victim returned for the victim address.
- R8: `evtCode` is one-hot while `evtValid` is high and zero otherwise. `evtValid` lasts one cycle and is followed by at least one idle cycle. `reqPop` is high only together with an access or conflict event.
- R9: `probeAddr` equals the L1 victim of the proper L1 exactly in the full-L1 case of R7, and equals `reqAddr` otherwise.
- R10: Driven by an exclusive array model that applies each event, every request finishes with a pop. At that point its line sits in its proper L1 only, exclusion holds across all arrays, and no conflict event has occurred.
- R11: While reset is held and until a valid request is seen, `evtValid` and `reqPop` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is at the queue head |
| reqKind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| reqAddr | input | ADDR_W | Request line address |
| hitL1i | input | 1 | Request line present in instruction L1 |
| hitL1d | input | 1 | Request line present in data L1 |
| hitL2 | input | 1 | Request line present in L2 |
| freeL1i | input | 1 | Instruction L1 set of reqAddr has a free way |
| freeL1d | input | 1 | Data L1 set of reqAddr has a free way |
| l1iVictim | input | ADDR_W | Victim line of the instruction L1 set of reqAddr |
| l1dVictim | input | ADDR_W | Victim line of the data L1 set of reqAddr |
| probeAddr | output | ADDR_W | Address presented to the L2 room/victim lookup |
| l2Room | input | 1 | L2 set of probeAddr has a free way |
| l2Victim | input | ADDR_W | L2 victim line for the set of probeAddr |
| evtValid | output | 1 | Event pulse |
| evtCode | output | 8 | One-hot event code |
| evtAddr | output | ADDR_W | Target line of the event |
| reqPop | output | 1 | Head request consumed |

## Verification
A sweep drives every combination of request kind, three presence flags, two L1 free flags, and two separate L2-room answers: one for the request address and one for any other probed address. The expected event, address, pop and probe address are computed in the bench. Because the two room answers and the two L1 victims differ, a wrong probe selection or a swapped L1 victim shows up as a wrong event or a wrong address. A second phase runs a stream of requests against an exclusive two-set array model that applies every event. This phase separates correct multi-step migration (evict, push down, pull up, access) from sequences that lose exclusion or never pop.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int EVT_W = 8;

  // One-hot event bit positions
  localparam int EV_LOAD      = 0;
  localparam int EV_FETCH     = 1;
  localparam int EV_STORE     = 2;
  localparam int EV_L1_TO_L2  = 3;
  localparam int EV_L2_TO_L1D = 4;
  localparam int EV_L2_TO_L1I = 5;
  localparam int EV_L2_EVICT  = 6;
  localparam int EV_CONFLICT  = 7;

  localparam logic [EVT_W-1:0] POP_MASK =
    EVT_W'((1 << EV_LOAD) | (1 << EV_FETCH) | (1 << EV_STORE) | (1 << EV_CONFLICT));

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    SRC_REQ       = 2'd0,
    SRC_L1_VICTIM = 2'd1,
    SRC_L2_VICTIM = 2'd2
  } addr_src_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [EVT_W-1:0] evt;
    addr_src_e        addrSrc;
    logic             pop;
  } steer_strobe_t;

endpackage

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
(
  input  logic [1:0]       reqKind,
  input  logic             hitL1i,
  input  logic             hitL1d,
  input  logic             hitL2,
  input  logic             freeL1i,
  input  logic             freeL1d,
  input  logic             l2Room,
  output logic [EVT_W-1:0] evt,
  output addr_src_e        addrSrc,
  output logic             pop,
  output logic             probeVictim
);

  logic isFetch, isWrite, hitOwn, hitOther, roomOwn, multiHit;
  logic [EVT_W-1:0] accessEvt;

  always_comb begin
    isFetch  = (reqKind == KIND_FETCH);
    isWrite  = reqKind[1];
    hitOwn   = isFetch ? hitL1i : hitL1d;
    hitOther = isFetch ? hitL1d : hitL1i;
    roomOwn  = isFetch ? freeL1i : freeL1d;
    multiHit = ($countones({hitL1i, hitL1d, hitL2}) > 1);

    accessEvt = '0;
    if (isFetch)      accessEvt[EV_FETCH] = 1'b1;
    else if (isWrite) accessEvt[EV_STORE] = 1'b1;
    else              accessEvt[EV_LOAD]  = 1'b1;

    // Only the full-L1 path looks up the L2 with the L1 victim.
    probeVictim = !multiHit && !hitL1i && !hitL1d && !roomOwn;
  end

  always_comb begin
    evt     = '0;
    addrSrc = SRC_REQ;
    pop     = 1'b0;
    if (multiHit) begin
      evt[EV_CONFLICT] = 1'b1;
      pop              = 1'b1;
    end else if (hitOther) begin
      if (l2Room) evt[EV_L1_TO_L2] = 1'b1;
      else begin
        evt[EV_L2_EVICT] = 1'b1;
        addrSrc          = SRC_L2_VICTIM;
      end
    end else if (hitOwn) begin
      evt = accessEvt;
      pop = 1'b1;
    end else if (roomOwn) begin
      if (hitL2) begin
        if (isFetch) evt[EV_L2_TO_L1I] = 1'b1;
        else         evt[EV_L2_TO_L1D] = 1'b1;
      end else begin
        evt = accessEvt;
        pop = 1'b1;
      end
    end else begin
      if (l2Room) begin
        evt[EV_L1_TO_L2] = 1'b1;
        addrSrc          = SRC_L1_VICTIM;
      end else begin
        evt[EV_L2_EVICT] = 1'b1;
        addrSrc          = SRC_L2_VICTIM;
      end
    end
  end

endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [1:0]    reqKind,
  input  logic          hitL1i,
  input  logic          hitL1d,
  input  logic          hitL2,
  input  logic          freeL1i,
  input  logic          freeL1d,
  input  logic          l2Room,
  output steer_strobe_t strobe,
  output logic          probeVictim
);

  typedef enum logic {ST_EVAL, ST_SETTLE} ctrl_state_e;
  ctrl_state_e state;

  logic [EVT_W-1:0] decEvt;
  addr_src_e        decSrc;
  logic             decPop;

  steer_classify u_classify (
    .reqKind     (reqKind),
    .hitL1i      (hitL1i),
    .hitL1d      (hitL1d),
    .hitL2       (hitL2),
    .freeL1i     (freeL1i),
    .freeL1d     (freeL1d),
    .l2Room      (l2Room),
    .evt         (decEvt),
    .addrSrc     (decSrc),
    .pop         (decPop),
    .probeVictim (probeVictim)
  );

  // One decision, then one cycle for the arrays to apply it.
  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_EVAL;
    else if (state == ST_EVAL && reqValid) state <= ST_SETTLE;
    else state <= ST_EVAL;
  end

  always_comb begin
    strobe.capture = (state == ST_EVAL) && reqValid;
    strobe.evt     = decEvt;
    strobe.addrSrc = decSrc;
    strobe.pop     = decPop;
  end

endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  steer_strobe_t     strobe,
  input  logic              probeVictim,
  input  logic              isFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] l1iVictim,
  input  logic [ADDR_W-1:0] l1dVictim,
  input  logic [ADDR_W-1:0] l2Victim,
  output logic [ADDR_W-1:0] probeAddr,
  output logic              evtValid,
  output logic [EVT_W-1:0]  evtCode,
  output logic [ADDR_W-1:0] evtAddr,
  output logic              reqPop
);

  logic [ADDR_W-1:0] l1Victim;
  logic [ADDR_W-1:0] targetAddr;

  always_comb begin
    l1Victim  = isFetch ? l1iVictim : l1dVictim;
    probeAddr = probeVictim ? l1Victim : reqAddr;
    unique case (strobe.addrSrc)
      SRC_L1_VICTIM: targetAddr = l1Victim;
      SRC_L2_VICTIM: targetAddr = l2Victim;
      default:       targetAddr = reqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtAddr  <= '0;
      reqPop   <= 1'b0;
    end else if (strobe.capture) begin
      evtValid <= 1'b1;
      evtCode  <= strobe.evt;
      evtAddr  <= targetAddr;
      reqPop   <= strobe.pop;
    end else begin
      evtValid <= 1'b0;
      evtCode  <= '0;
      reqPop   <= 1'b0;
    end
  end

endmodule

// File: rtl/excl_cache_steer.sv
module excl_cache_steer
  import steer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              hitL1i,
  input  logic              hitL1d,
  input  logic              hitL2,
  input  logic              freeL1i,
  input  logic              freeL1d,
  input  logic [ADDR_W-1:0] l1iVictim,
  input  logic [ADDR_W-1:0] l1dVictim,
  output logic [ADDR_W-1:0] probeAddr,
  input  logic              l2Room,
  input  logic [ADDR_W-1:0] l2Victim,
  output logic              evtValid,
  output logic [7:0]        evtCode,
  output logic [ADDR_W-1:0] evtAddr,
  output logic              reqPop
);

  steer_strobe_t strobe;
  logic          probeVictim;

  steer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .hitL1i      (hitL1i),
    .hitL1d      (hitL1d),
    .hitL2       (hitL2),
    .freeL1i     (freeL1i),
    .freeL1d     (freeL1d),
    .l2Room      (l2Room),
    .strobe      (strobe),
    .probeVictim (probeVictim)
  );

  steer_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .probeVictim (probeVictim),
    .isFetch     (reqKind == KIND_FETCH),
    .reqAddr     (reqAddr),
    .l1iVictim   (l1iVictim),
    .l1dVictim   (l1dVictim),
    .l2Victim    (l2Victim),
    .probeAddr   (probeAddr),
    .evtValid    (evtValid),
    .evtCode     (evtCode),
    .evtAddr     (evtAddr),
    .reqPop      (reqPop)
  );

endmodule

// File: rtl/excl_cache_steer_checker.sv
module excl_cache_steer_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              evtValid,
  input logic [7:0]        evtCode,
  input logic [ADDR_W-1:0] evtAddr,
  input logic              reqPop
);

  // R8: exactly one event bit while valid
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> ($countones(evtCode) == 1));

  // R8: no stray code bits between events
  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |-> (evtCode == 8'h00));

  // R8: a pulse is always followed by an idle cycle
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> !evtValid);

  // R8: pop only with an access or conflict event
  assert_pop_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reqPop |-> (evtValid && ((evtCode & 8'h87) != 8'h00)));

  // R2: moves and evictions never consume the request
  assert_move_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && ((evtCode & 8'h78) != 8'h00)) |-> !reqPop);

  // R4: an event only follows a presented request
  assert_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> $past(reqValid));

  // R4: access events target the request address
  assert_access_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && ((evtCode & 8'h07) != 8'h00)) |-> (evtAddr == $past(reqAddr)));

endmodule

bind excl_cache_steer excl_cache_steer_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .evtValid (evtValid),
  .evtCode  (evtCode),
  .evtAddr  (evtAddr),
  .reqPop   (reqPop)
);

// File: tb/excl_cache_steer_tb.sv
`timescale 1ns/1ps
module excl_cache_steer_tb;

  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid;
  logic [1:0]    reqKind;
  logic [AW-1:0] reqAddr;
  logic          hitL1i, hitL1d, hitL2, freeL1i, freeL1d, l2Room;
  logic [AW-1:0] l1iVictim, l1dVictim, l2Victim, probeAddr;
  logic          evtValid, reqPop;
  logic [7:0]    evtCode;
  logic [AW-1:0] evtAddr;

  excl_cache_steer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .hitL1i(hitL1i), .hitL1d(hitL1d), .hitL2(hitL2), .freeL1i(freeL1i), .freeL1d(freeL1d),
    .l1iVictim(l1iVictim), .l1dVictim(l1dVictim), .probeAddr(probeAddr),
    .l2Room(l2Room), .l2Victim(l2Victim),
    .evtValid(evtValid), .evtCode(evtCode), .evtAddr(evtAddr), .reqPop(reqPop)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // ---------------- stimulus sources ----------------
  bit useModel;
  // sweep-mode drivers
  logic sHitI, sHitD, sHit2, sFreeI, sFreeD, sRoomReq, sRoomOther;
  // model: 2 sets; L1s one way, L2 two ways; set = addr[0]
  logic          mIv [2];
  logic [AW-1:0] mIa [2];
  logic          mDv [2];
  logic [AW-1:0] mDa [2];
  logic          m2v [2][2];
  logic [AW-1:0] m2a [2][2];
  logic          m2p [2];

  always_comb begin
    if (!useModel) begin
      hitL1i = sHitI; hitL1d = sHitD; hitL2 = sHit2;
      freeL1i = sFreeI; freeL1d = sFreeD;
      l1iVictim = reqAddr ^ 6'h14;
      l1dVictim = reqAddr ^ 6'h28;
      l2Room    = (probeAddr == reqAddr) ? sRoomReq : sRoomOther;
      l2Victim  = probeAddr ^ 6'h2A;
    end else begin
      hitL1i = mIv[reqAddr[0]] && mIa[reqAddr[0]] == reqAddr;
      hitL1d = mDv[reqAddr[0]] && mDa[reqAddr[0]] == reqAddr;
      hitL2  = (m2v[reqAddr[0]][0] && m2a[reqAddr[0]][0] == reqAddr) ||
               (m2v[reqAddr[0]][1] && m2a[reqAddr[0]][1] == reqAddr);
      freeL1i = !mIv[reqAddr[0]];
      freeL1d = !mDv[reqAddr[0]];
      l1iVictim = mIa[reqAddr[0]];
      l1dVictim = mDa[reqAddr[0]];
      l2Room   = !m2v[probeAddr[0]][0] || !m2v[probeAddr[0]][1];
      l2Victim = m2a[probeAddr[0]][m2p[probeAddr[0]]];
    end
  end

  // ---------------- model actions ----------------
  task automatic modelApply(input logic [7:0] code, input logic [AW-1:0] a, input logic [1:0] kind);
    int s;
    s = a[0];
    if (code[3]) begin // L1 -> L2
      if (mIv[s] && mIa[s] == a) mIv[s] = 0; else mDv[s] = 0;
      if (!m2v[s][0]) begin m2v[s][0] = 1; m2a[s][0] = a; end
      else begin m2v[s][1] = 1; m2a[s][1] = a; end
    end else if (code[4] || code[5]) begin // L2 -> L1
      for (int w = 0; w < 2; w++) if (m2v[s][w] && m2a[s][w] == a) m2v[s][w] = 0;
      if (code[5]) begin mIv[s] = 1; mIa[s] = a; end
      else begin mDv[s] = 1; mDa[s] = a; end
    end else if (code[6]) begin // L2 evict
      for (int w = 0; w < 2; w++) if (m2v[s][w] && m2a[s][w] == a) m2v[s][w] = 0;
      m2p[s] = !m2p[s];
    end else if (code[2:0] != 0) begin // access: fill on miss
      if (kind == 2'd1) begin
        if (!(mIv[s] && mIa[s] == a)) begin mIv[s] = 1; mIa[s] = a; end
      end else begin
        if (!(mDv[s] && mDa[s] == a)) begin mDv[s] = 1; mDa[s] = a; end
      end
    end
  endtask

  function automatic bit exclusive();
    bit ok = 1;
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) if (m2v[s][w]) begin
        if (mIv[s] && mIa[s] == m2a[s][w]) ok = 0;
        if (mDv[s] && mDa[s] == m2a[s][w]) ok = 0;
      end
      if (mIv[s] && mDv[s] && mIa[s] == mDa[s]) ok = 0;
      if (m2v[s][0] && m2v[s][1] && m2a[s][0] == m2a[s][1]) ok = 0;
    end
    return ok;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  // ---------------- main ----------------
  initial begin
    useModel = 0;
    reqValid = 0; reqKind = 0; reqAddr = 0;
    {sHitI, sHitD, sHit2, sFreeI, sFreeD, sRoomReq, sRoomOther} = '0;
    for (int s = 0; s < 2; s++) begin
      mIv[s] = 0; mDv[s] = 0; mIa[s] = 0; mDa[s] = 0; m2p[s] = 0;
      for (int w = 0; w < 2; w++) begin m2v[s][w] = 0; m2a[s][w] = 0; end
    end

    // R11: quiet during and right after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!evtValid && !reqPop, "R11 in reset", {evtValid, reqPop}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!evtValid && !reqPop, "R11 idle after reset", {evtValid, reqPop}, 0);

    // ---------- Phase 1: exhaustive decision sweep ----------
    for (int c = 0; c < 512; c++) begin
      logic [7:0] eCode; logic [AW-1:0] eAddr, eProbe, vic; bit ePop, fetch, own, other, room;
      int n; string tag;
      reqKind = c[1:0]; sHitI = c[2]; sHitD = c[3]; sHit2 = c[4];
      sFreeI = c[5]; sFreeD = c[6]; sRoomReq = c[7]; sRoomOther = c[8];
      reqAddr = AW'(c * 7 + 3);
      reqValid = 1;

      fetch = (reqKind == 2'd1);
      own   = fetch ? sHitI : sHitD;
      other = fetch ? sHitD : sHitI;
      room  = fetch ? sFreeI : sFreeD;
      vic   = fetch ? (reqAddr ^ 6'h14) : (reqAddr ^ 6'h28);
      n = int'(sHitI) + int'(sHitD) + int'(sHit2);
      eCode = 0; eAddr = reqAddr; ePop = 0; eProbe = reqAddr;
      if (n > 1) begin eCode = 8'h80; ePop = 1; tag = "R1"; end
      else if (other) begin
        if (sRoomReq) begin eCode = 8'h08; tag = "R2"; end
        else begin eCode = 8'h40; eAddr = reqAddr ^ 6'h2A; tag = "R3"; end
      end else if (own) begin
        eCode = fetch ? 8'h02 : (reqKind[1] ? 8'h04 : 8'h01); ePop = 1; tag = "R4";
      end else if (room) begin
        if (sHit2) begin eCode = fetch ? 8'h20 : 8'h10; tag = "R5"; end
        else begin eCode = fetch ? 8'h02 : (reqKind[1] ? 8'h04 : 8'h01); ePop = 1; tag = "R6"; end
      end else begin
        eProbe = vic; tag = "R7";
        if (sRoomOther) begin eCode = 8'h08; eAddr = vic; end
        else begin eCode = 8'h40; eAddr = vic ^ 6'h2A; end
      end

      #1;
      if (c % 8 == 0 || tag == "R7")
        check(probeAddr == eProbe, "R9 probe", probeAddr, eProbe);
      @(posedge clk);
      @(negedge clk);
      reqValid = 0;
      check(evtValid && evtCode == eCode, {tag, " code"}, {evtValid, evtCode}, {1'b1, eCode});
      check(evtAddr == eAddr, {tag, " addr"}, evtAddr, eAddr);
      check(reqPop == ePop, {tag, " pop"}, reqPop, ePop);
      @(posedge clk);
      @(negedge clk);
      if (c % 16 == 0)
        check(!evtValid && evtCode == 0 && !reqPop, "R8 pulse", {evtValid, evtCode}, 0);
    end

    // ---------- Phase 2: exclusive array model ----------
    useModel = 1;
    for (int i = 0; i < 64; i++) begin
      int steps; bit popped; bit sawConflict; int s; bit placed;
      reqAddr = AW'((i * 7 + i / 4) % 10);
      reqKind = 2'((i + i / 3) % 4);
      reqValid = 1;
      steps = 0; popped = 0; sawConflict = 0;
      while (!popped && steps < 9) begin
        @(posedge clk);
        @(negedge clk);
        if (!evtValid) begin
          check(0, "R8 no event", 0, 1);
          steps = 9;
        end else begin
          if (evtCode[7]) sawConflict = 1;
          modelApply(evtCode, evtAddr, reqKind);
          popped = reqPop;
          steps++;
          if (popped) reqValid = 0;
          @(posedge clk);
          @(negedge clk);
        end
      end
      s = reqAddr[0];
      if (reqKind == 2'd1)
        placed = mIv[s] && mIa[s] == reqAddr && !(mDv[s] && mDa[s] == reqAddr);
      else
        placed = mDv[s] && mDa[s] == reqAddr && !(mIv[s] && mIa[s] == reqAddr);
      check(popped && !sawConflict, "R10 popped", {popped, sawConflict}, 2'b10);
      check(placed && exclusive(), "R10 placement", {placed, exclusive()}, 2'b11);
    end

    finishRun();
  end

endmodule